// File: doc/BRIEF.md
# Dual-Chemistry Battery Charge Sequencer

This block sequences charging of a single lithium-ion pack or a three-cell nickel-metal-hydride pack. It reads synchronous comparator flags: two adapter-versus-battery margins (a wide one and a narrow one), the battery's undervoltage-lockout, 4.0 V, 4.2 V and 5.5 V comparisons, and whether the sense-resistor voltage is still above the termination level. From these flags it selects the charge current limit, flags constant-voltage operation, drives the pass-transistor gate and reports adapter presence and end of charge.

With the processor's mode input low, hardware runs the lithium path. It trickle-charges below lockout, then charges at constant current, then at constant voltage, and it raises end of charge near the end. With the mode input high, hardware gives up gate control and the processor pulses the gate itself for NiMH charging. A battery above 5.5 V forces the pass device off. Loss of the adapter returns the block to idle.

Top module: `chg_mode_ctrl`

## Requirements
- R1: An internal adapter-present flag sets one clock after `adp_hi_i` is high and clears one clock after `adp_lo_i` is low. Between those two events it holds, so a high `adp_lo_i` alone never sets it.
- R2: `chg_det_o` is the adapter-present flag gated by `bat_uvlo_ok_i`. It stays low while the battery is below lockout, even when the adapter is present.
- R3: When the adapter is present, `chgen_i` is low and `bat_uvlo_ok_i` is low, the sequencer is in trickle charge: `ilim_full_o`=0 (low limit), `gate_off_o`=0 and `cv_mode_o`=0.
- R4: When the adapter is present, `chgen_i` is low, the battery is above lockout and `bat_ge_cv_i` is low, the charge runs at constant current: `ilim_full_o`=1, `cv_mode_o`=0, `gate_off_o`=0.
- R5: `bat_ge_cv_i` high during hardware charging enters constant voltage (`cv_mode_o`=1, `ilim_full_o`=1). The mode stays set while the adapter is present and `chgen_i` is low, even if `bat_ge_cv_i` falls again.
- R6: During constant current or constant voltage, `bat_ge_eoc_i`=1 together with `sense_hi_i`=0 sets `eoc_o` on the next clock. Charging continues with `gate_off_o`=0.
- R7: Once set, `eoc_o` holds even if `sense_hi_i` rises again. It clears on the clock after `bat_ge_eoc_i` is low or the adapter-present flag is low.
- R8: With `chgen_i` high, `ilim_full_o`=1 and `cv_mode_o`=0. `gate_off_o` follows `gatein_i` in the same cycle (1 = pass device off). Driving both inputs high terminates charging.
- R9: In processor-gated mode, `bat_over_i` high forces `gate_off_o`=1 in the same cycle, whatever `gatein_i` is.
- R10: On the clock after the adapter-present flag drops, the block goes idle: `gate_off_o`=1, `ilim_full_o`=0, `cv_mode_o`=0. Outputs therefore settle two clocks after the adapter margin inputs change.
- R11: While `rst_ni` is low, `gate_off_o`=1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adp_hi_i | input | 1 | Adapter above battery by the wide (set) margin |
| adp_lo_i | input | 1 | Adapter above battery by the narrow (hold) margin |
| bat_uvlo_ok_i | input | 1 | Battery above undervoltage lockout |
| bat_ge_cv_i | input | 1 | Battery at or above 4.2 V |
| bat_ge_eoc_i | input | 1 | Battery above 4.0 V |
| bat_over_i | input | 1 | Battery above 5.5 V |
| sense_hi_i | input | 1 | Sense-resistor voltage above the 14 mV termination level |
| chgen_i | input | 1 | Processor mode: 0 hardware lithium path, 1 processor-gated |
| gatein_i | input | 1 | Processor gate command: 1 off, 0 on |
| chg_det_o | output | 1 | Charger detected |
| ilim_full_o | output | 1 | Current limit select: 1 full, 0 trickle |
| cv_mode_o | output | 1 | Constant-voltage mode |
| gate_off_o | output | 1 | Pass-transistor gate drive: 1 off, 0 on |
| eoc_o | output | 1 | End of charge |

## Verification
The hardest state to reach is a constant-voltage charge whose end-of-charge flag must outlive a rising sense flag and a falling 4.2 V flag. Both conditions depend on an ordered history, not on the present inputs. The stimulus table therefore walks one continuous session: adapter arrival below lockout, lockout release, 4.0 V, 4.2 V and termination in turn. Each flag is then withdrawn one at a time. After that, a directed sequence rebuilds the end-of-charge state and removes the adapter, which checks that the flag clears through presence loss and not through the battery comparison.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TRICKLE = 3'd1,
    ST_CC      = 3'd2,
    ST_CV      = 3'd3,
    ST_EXT     = 3'd4
  } chg_state_e;
endpackage

// File: rtl/chg_presence.sv
module chg_presence (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adp_hi_i,
  input  logic adp_lo_i,
  input  logic bat_uvlo_ok_i,
  output logic present_o,
  output logic chg_det_o
);
  logic present_q;

  // hysteresis: wide margin sets, narrow margin holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        present_q <= 1'b0;
    else if (present_q) present_q <= adp_lo_i;
    else                present_q <= adp_hi_i;
  end

  assign present_o = present_q;
  assign chg_det_o = present_q & bat_uvlo_ok_i;

  p_hold_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_q && !adp_lo_i |=> !present_q);
  p_no_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_q && !adp_hi_i |=> !present_q);
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       present_i,
  input  logic       bat_uvlo_ok_i,
  input  logic       bat_ge_cv_i,
  input  logic       bat_over_i,
  input  logic       chgen_i,
  input  logic       gatein_i,
  output chg_state_e state_o,
  output logic       ilim_full_o,
  output logic       cv_mode_o,
  output logic       gate_off_o
);
  chg_state_e st_q, st_d;

  always_comb begin
    if (!present_i)                           st_d = ST_IDLE;
    else if (chgen_i)                         st_d = ST_EXT;
    else if (!bat_uvlo_ok_i)                  st_d = ST_TRICKLE;
    else if (bat_ge_cv_i || st_q == ST_CV)    st_d = ST_CV;
    else                                      st_d = ST_CC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    ilim_full_o = 1'b0;
    cv_mode_o   = 1'b0;
    gate_off_o  = 1'b0;
    unique case (st_q)
      ST_IDLE:    gate_off_o = 1'b1;
      ST_TRICKLE: ;
      ST_CC:      ilim_full_o = 1'b1;
      ST_CV: begin
        ilim_full_o = 1'b1;
        cv_mode_o   = 1'b1;
      end
      ST_EXT: begin
        ilim_full_o = 1'b1;
        gate_off_o  = gatein_i | bat_over_i;  // over-voltage cut is unconditional
      end
      default:    gate_off_o = 1'b1;
    endcase
  end

  assign state_o = st_q;

  p_trickle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_i && !chgen_i && !bat_uvlo_ok_i |=> !ilim_full_o && !gate_off_o);
  p_cv_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cv_mode_o && present_i && !chgen_i |=> cv_mode_o);
  p_over_cut_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_EXT && bat_over_i |-> gate_off_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i |=> gate_off_o && !ilim_full_o && !cv_mode_o);
endmodule

// File: rtl/chg_eoc_flag.sv
module chg_eoc_flag
  import chg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       present_i,
  input  chg_state_e state_i,
  input  logic       bat_ge_eoc_i,
  input  logic       sense_hi_i,
  output logic       eoc_o
);
  logic eoc_q;
  logic hw_full;

  assign hw_full = (state_i == ST_CC) || (state_i == ST_CV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             eoc_q <= 1'b0;
    else if (!present_i || !bat_ge_eoc_i)    eoc_q <= 1'b0;
    else if (hw_full && !sense_hi_i)         eoc_q <= 1'b1;
  end

  assign eoc_o = eoc_q;

  p_eoc_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_q && !bat_ge_eoc_i |=> !eoc_q);
  p_eoc_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_i && hw_full && bat_ge_eoc_i && !sense_hi_i |=> eoc_q);
endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl
  import chg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adp_hi_i,
  input  logic adp_lo_i,
  input  logic bat_uvlo_ok_i,
  input  logic bat_ge_cv_i,
  input  logic bat_ge_eoc_i,
  input  logic bat_over_i,
  input  logic sense_hi_i,
  input  logic chgen_i,
  input  logic gatein_i,
  output logic chg_det_o,
  output logic ilim_full_o,
  output logic cv_mode_o,
  output logic gate_off_o,
  output logic eoc_o
);
  logic       present;
  chg_state_e state;

  chg_presence i_presence (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .adp_hi_i      (adp_hi_i),
    .adp_lo_i      (adp_lo_i),
    .bat_uvlo_ok_i (bat_uvlo_ok_i),
    .present_o     (present),
    .chg_det_o     (chg_det_o)
  );

  chg_seq_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .present_i     (present),
    .bat_uvlo_ok_i (bat_uvlo_ok_i),
    .bat_ge_cv_i   (bat_ge_cv_i),
    .bat_over_i    (bat_over_i),
    .chgen_i       (chgen_i),
    .gatein_i      (gatein_i),
    .state_o       (state),
    .ilim_full_o   (ilim_full_o),
    .cv_mode_o     (cv_mode_o),
    .gate_off_o    (gate_off_o)
  );

  chg_eoc_flag i_eoc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .present_i    (present),
    .state_i      (state),
    .bat_ge_eoc_i (bat_ge_eoc_i),
    .sense_hi_i   (sense_hi_i),
    .eoc_o        (eoc_o)
  );

  p_det_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bat_uvlo_ok_i |-> !chg_det_o);
  p_ext_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(present && chgen_i) && present && chgen_i && !bat_over_i |-> gate_off_o == gatein_i);
endmodule

// File: tb/test_chg_mode_ctrl.sv
module test_chg_mode_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic adp_hi, adp_lo, uvlo_ok, ge_cv, ge_eoc, over, sense_hi, chgen, gatein;
  logic det, full, cvm, goff, eoc;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  chg_mode_ctrl i_chg_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .adp_hi_i(adp_hi), .adp_lo_i(adp_lo), .bat_uvlo_ok_i(uvlo_ok),
    .bat_ge_cv_i(ge_cv), .bat_ge_eoc_i(ge_eoc), .bat_over_i(over),
    .sense_hi_i(sense_hi), .chgen_i(chgen), .gatein_i(gatein),
    .chg_det_o(det), .ilim_full_o(full), .cv_mode_o(cvm),
    .gate_off_o(goff), .eoc_o(eoc)
  );

  // inputs: hi lo uvlo cv eoc4 over sense chgen gatein | expect: det full cv goff eoc
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {9'b000000000, 5'b00010},
    {9'b110000000, 5'b00000},
    {9'b111000000, 5'b11000},
    {9'b011000000, 5'b11000},
    {9'b011010100, 5'b11000},
    {9'b011110100, 5'b11100},
    {9'b011010000, 5'b11101},
    {9'b011010100, 5'b11101},
    {9'b011000100, 5'b11100},
    {9'b011000110, 5'b11000},
    {9'b011000111, 5'b11010},
    {9'b011001110, 5'b11010},
    {9'b011000110, 5'b11000},
    {9'b011000100, 5'b11000},
    {9'b001000100, 5'b00010},
    {9'b011000100, 5'b00010}
  };
  string vreq [NV] = '{"R11", "R3", "R4", "R1", "R4", "R5", "R6", "R7",
                       "R7", "R8", "R8", "R9", "R8", "R4", "R10", "R1"};

  task automatic chk(input string rq, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", rq, nm, act, exp);
    end
  endtask

  task automatic chk_all(input string rq, input logic [4:0] e);
    chk(rq, "chg_det",   det,  e[4]);
    chk(rq, "ilim_full", full, e[3]);
    chk(rq, "cv_mode",   cvm,  e[2]);
    chk(rq, "gate_off",  goff, e[1]);
    chk(rq, "eoc",       eoc,  e[0]);
  endtask

  task automatic drive(input logic [8:0] v);
    {adp_hi, adp_lo, uvlo_ok, ge_cv, ge_eoc, over, sense_hi, chgen, gatein} = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    drive(9'b0);
    #1;
    chk_all("R11", 5'b00010);  // reset values
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][13:5]);
      repeat (3) @(negedge clk);
      chk_all(vreq[i], VEC[i][4:0]);
    end

    // R1 / R10 latency: flag after one edge, outputs after two
    @(negedge clk);
    drive(9'b111000000);
    @(negedge clk);
    chk("R1", "chg_det one edge", det, 1'b1);
    chk("R10", "gate_off still idle", goff, 1'b1);
    @(negedge clk);
    chk("R4", "gate_off after two edges", goff, 1'b0);
    chk("R4", "ilim_full after two edges", full, 1'b1);

    // R7: build end of charge, then remove the adapter
    drive(9'b111110000);
    repeat (3) @(negedge clk);
    chk("R6", "eoc in cv", eoc, 1'b1);
    chk("R6", "gate_on during eoc", goff, 1'b0);
    drive(9'b001110000);
    repeat (3) @(negedge clk);
    chk("R7", "eoc cleared by adapter loss", eoc, 1'b0);
    chk("R10", "gate_off after loss", goff, 1'b1);
    chk("R10", "cv cleared after loss", cvm, 1'b0);

    // R2: adapter present below lockout keeps det low but trickle runs
    drive(9'b110000000);
    repeat (3) @(negedge clk);
    chk("R2", "chg_det below lockout", det, 1'b0);
    chk("R3", "trickle gate on", goff, 1'b0);
    chk("R3", "trickle limit", full, 1'b0);

    // R8 / R9 same-cycle response in processor-gated mode
    drive(9'b111000010);
    repeat (3) @(negedge clk);
    chk("R8", "ext gate on", goff, 1'b0);
    gatein = 1'b1;
    #1;
    chk("R8", "gate follows gatein same cycle", goff, 1'b1);
    gatein = 1'b0;
    over = 1'b1;
    #1;
    chk("R9", "over cut same cycle", goff, 1'b1);
    over = 1'b0;
    #1;
    chk("R9", "cut released", goff, 1'b0);

    // R11: reset mid-charge
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk_all("R11", 5'b00010);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(9'b0);
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule